// File: doc/BRIEF.md
# USB Endpoint Command and Status Controller

This block holds the per-endpoint status state of a full-speed USB device controller that has sixteen endpoints: index 0 is the control OUT endpoint, index 1 the control IN endpoint, and indices 2 to 15 are the general endpoints 1 to 14. On the CPU side it accepts 8-bit command codes to halt, resume and arm endpoints. Any endpoint's 8-bit status byte can be read combinationally. On the USB side it takes single-cycle event pulses for a SETUP token, the end of the setup data write, an acknowledged IN packet and a received OUT packet.

For each endpoint the block tracks the halt flag, two buffer-full flags, the next data PID, the setup-present and setup-overwrite flags, and which buffer half the CPU is using. By default the general endpoints are double-buffered and the two control endpoints are single-buffered. A private pointer per endpoint follows which buffer half the USB side uses next. A SETUP token always releases a halt on the control pair and restarts both endpoints from a clean state. Setup data that a second SETUP overwrites is flagged until the CPU reads the status byte.

Top module: `usb_ep_ctrl`

## Requirements
- R1: After reset every status byte reads 0x00: not halted, both buffers empty, DATA0 next, primary buffer selected for the CPU.
- R2: A command with cmd_code 0x40+n sets bit 7 (halted) of endpoint n. A command with 0x80+n clears it. n runs over 0..15, where 0 is control OUT and 1 is control IN.
- R3: A resume (0x80+n) restarts endpoint n: bits 7, 6, 5, 4, 2 and 1 all read 0 afterwards.
- R4: ev_setup clears the halt of endpoints 0 and 1 and restarts both of them in the same way as R3, regardless of their prior contents.
- R5: An arm command 0x60+n, for n from 1 to 15, sets the full flag of the buffer the CPU has selected: bit 5 if bit 1 is 0, bit 6 if bit 1 is 1. On a double-buffered endpoint (n of 2 or more) it also inverts bit 1. On endpoint 1, bit 1 stays 0.
- R6: ev_in_ack on a non-halted endpoint whose USB-side buffer is full clears that full flag and inverts bit 4. On a double-buffered endpoint the USB side then moves to the other half. Otherwise the event has no effect.
- R7: ev_out_rx on a non-halted endpoint whose USB-side buffer is empty sets that full flag and inverts bit 4, with the same pointer movement as R6. Otherwise the event has no effect.
- R8: ev_setup_done sets bit 2 (setup present) and bit 5 of endpoint 0 and ends the setup write.
- R9: An ev_setup that arrives while bit 2 of endpoint 0 is set also sets bit 3 (setup overwrite) of endpoint 0.
- R10: rd_data shows the status byte of endpoint rd_ep as it was before any clear. When rd_en targets endpoint 0 and no setup write is in progress, bit 3 is cleared at the clock edge. If an overwrite per R9 happens in the same cycle, bit 3 stays set.
- R11: Command codes outside 0x40..0x4F, 0x61..0x6F and 0x80..0x8F (for example 0x00, 0x3F, 0x50, 0x60, 0x90, 0xFF) change no status bit.
- R12: A halt command on endpoint 0 (0x40) also clears its bit 2.
- R13: Bit 0 of every status byte always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_code | input | 8 | Command code |
| rd_en | input | 1 | Status read strobe (clear-on-read qualifier) |
| rd_ep | input | 4 | Endpoint whose status byte is shown |
| rd_data | output | 8 | Status byte of endpoint rd_ep |
| ev_setup | input | 1 | SETUP token received on the control pair |
| ev_setup_done | input | 1 | Setup data write into endpoint 0 finished |
| ev_in_ack | input | 1 | IN packet acknowledged on endpoint ev_ep |
| ev_out_rx | input | 1 | Valid OUT packet received on endpoint ev_ep |
| ev_ep | input | 4 | Endpoint index for ev_in_ack and ev_out_rx |

## Verification
The properties assume that at most one USB event pulses in a cycle, that a command and a USB event never target the same endpoint in one cycle, and that ev_setup_done only follows an ev_setup. The bench drives exactly one operation per cycle. The single exception is a read of endpoint 0 issued together with a SETUP token, which exercises the same-cycle overwrite rule. A reference model built from the requirements predicts every status byte, and the bench reads back all sixteen endpoints after the ignored-code sequence.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;

    // Status byte, MSB first; the bit order is fixed by the CPU view.
    typedef struct packed {
        logic halted;     // bit 7
        logic full_b;     // bit 6  secondary half full
        logic full_a;     // bit 5  primary half full
        logic next_pid;   // bit 4  0 = DATA0, 1 = DATA1
        logic setup_ovw;  // bit 3
        logic setup_here; // bit 2
        logic cpu_sel;    // bit 1  0 = primary, 1 = secondary
        logic spare;      // bit 0  always 0
    } ep_stat_t;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_HALT,
        OP_RESUME,
        OP_ARM
    } ep_op_e;

    localparam logic [3:0] GRP_HALT   = 4'h4;
    localparam logic [3:0] GRP_ARM    = 4'h6;
    localparam logic [3:0] GRP_RESUME = 4'h8;

    function automatic ep_op_e decode_op(input logic [7:0] code);
        ep_op_e op;
        case (code[7:4])
            GRP_HALT:   op = OP_HALT;
            GRP_RESUME: op = OP_RESUME;
            GRP_ARM:    op = (code[3:0] != 4'h0) ? OP_ARM : OP_NONE;
            default:    op = OP_NONE;
        endcase
        return op;
    endfunction

    // Restart: everything cleared except the overwrite flag, which has its own rule.
    function automatic ep_stat_t restart(input ep_stat_t s);
        ep_stat_t r;
        r = '0;
        r.setup_ovw = s.setup_ovw;
        return r;
    endfunction

    function automatic logic half_full(input ep_stat_t s, input logic sel);
        return sel ? s.full_b : s.full_a;
    endfunction

endpackage

// File: rtl/usb_ep_cmd_dec.sv
module usb_ep_cmd_dec
    import usb_ep_pkg::*;
#(
    parameter int NUM_EP = 16
) (
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_code,
    output logic [NUM_EP-1:0] halt_vec,
    output logic [NUM_EP-1:0] resume_vec,
    output logic [NUM_EP-1:0] arm_vec
);

    ep_op_e op;
    assign op = cmd_valid ? decode_op(cmd_code) : OP_NONE;

    for (genvar i = 0; i < NUM_EP; i++) begin : g_sel
        logic hit;
        assign hit           = (cmd_code[3:0] == 4'(i));
        assign halt_vec[i]   = hit && (op == OP_HALT);
        assign resume_vec[i] = hit && (op == OP_RESUME);
        assign arm_vec[i]    = hit && (op == OP_ARM);
    end

endmodule

// File: rtl/usb_ep_slot.sv
module usb_ep_slot
    import usb_ep_pkg::*;
#(
    parameter bit IS_DOUBLE   = 1'b0,
    parameter bit IS_CONTROL  = 1'b0,
    parameter bit IS_SETUP_EP = 1'b0
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     halt,
    input  logic     resume,
    input  logic     arm,
    input  logic     setup_tok,
    input  logic     setup_done,
    input  logic     in_ack,
    input  logic     out_rx,
    input  logic     rd_clr,
    output ep_stat_t stat
);

    ep_stat_t cur, nxt;
    logic     usb_sel, usb_nxt;

    always_comb begin
        nxt     = cur;
        usb_nxt = usb_sel;

        // USB side: packet traffic on the half the USB pointer names
        if (in_ack && !cur.halted && half_full(cur, usb_sel)) begin
            if (usb_sel) nxt.full_b = 1'b0;
            else         nxt.full_a = 1'b0;
            nxt.next_pid = ~cur.next_pid;
            if (IS_DOUBLE) usb_nxt = ~usb_sel;
        end
        if (out_rx && !cur.halted && !half_full(cur, usb_sel)) begin
            if (usb_sel) nxt.full_b = 1'b1;
            else         nxt.full_a = 1'b1;
            nxt.next_pid = ~cur.next_pid;
            if (IS_DOUBLE) usb_nxt = ~usb_sel;
        end
        if (IS_SETUP_EP && setup_done) begin
            nxt.setup_here = 1'b1;
            nxt.full_a     = 1'b1;
        end
        if (IS_CONTROL && setup_tok) begin
            nxt     = restart(nxt);
            usb_nxt = 1'b0;
        end

        // CPU side commands
        if (halt) begin
            nxt.halted = 1'b1;
            if (IS_SETUP_EP) nxt.setup_here = 1'b0;
        end
        if (resume) begin
            nxt     = restart(nxt);
            usb_nxt = 1'b0;
        end
        if (arm) begin
            if (cur.cpu_sel) nxt.full_b = 1'b1;
            else             nxt.full_a = 1'b1;
            if (IS_DOUBLE) nxt.cpu_sel = ~cur.cpu_sel;
        end

        // Overwrite: clear-on-read loses to a simultaneous new overwrite
        if (IS_SETUP_EP)
            nxt.setup_ovw = (cur.setup_ovw & ~rd_clr) | (setup_tok & cur.setup_here);
        else
            nxt.setup_ovw = 1'b0;
        nxt.spare = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur     <= '0;
            usb_sel <= 1'b0;
        end else begin
            cur     <= nxt;
            usb_sel <= usb_nxt;
        end
    end

    assign stat = cur;

endmodule

// File: rtl/usb_ep_ctrl.sv
module usb_ep_ctrl
    import usb_ep_pkg::*;
#(
    parameter int              NUM_EP   = 16,
    parameter logic [NUM_EP-1:0] DBL_MASK = 16'hFFFC,
    localparam int             EP_W     = $clog2(NUM_EP)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_valid,
    input  logic [7:0]      cmd_code,
    input  logic            rd_en,
    input  logic [EP_W-1:0] rd_ep,
    output logic [7:0]      rd_data,
    input  logic            ev_setup,
    input  logic            ev_setup_done,
    input  logic            ev_in_ack,
    input  logic            ev_out_rx,
    input  logic [EP_W-1:0] ev_ep
);

    logic [NUM_EP-1:0]   halt_vec, resume_vec, arm_vec;
    ep_stat_t            stat_arr [NUM_EP];
    logic [NUM_EP*8-1:0] stat_flat;
    logic                setup_wip;

    usb_ep_cmd_dec #(.NUM_EP(NUM_EP)) u_dec (
        .cmd_valid  (cmd_valid),
        .cmd_code   (cmd_code),
        .halt_vec   (halt_vec),
        .resume_vec (resume_vec),
        .arm_vec    (arm_vec)
    );

    // Setup write in progress: from SETUP token until its data is stored
    always_ff @(posedge clk) begin
        if (rst)                setup_wip <= 1'b0;
        else if (ev_setup)      setup_wip <= 1'b1;
        else if (ev_setup_done) setup_wip <= 1'b0;
    end

    for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
        logic sel_ev, sel_rd;
        assign sel_ev = (ev_ep == EP_W'(i));
        assign sel_rd = (rd_ep == EP_W'(i));

        usb_ep_slot #(
            .IS_DOUBLE   (DBL_MASK[i]),
            .IS_CONTROL  (i < 2),
            .IS_SETUP_EP (i == 0)
        ) u_slot (
            .clk        (clk),
            .rst        (rst),
            .halt       (halt_vec[i]),
            .resume     (resume_vec[i]),
            .arm        (arm_vec[i]),
            .setup_tok  (ev_setup),
            .setup_done (ev_setup_done),
            .in_ack     (ev_in_ack && sel_ev),
            .out_rx     (ev_out_rx && sel_ev),
            .rd_clr     (rd_en && sel_rd && !setup_wip),
            .stat       (stat_arr[i])
        );

        assign stat_flat[i*8 +: 8] = stat_arr[i];
    end

    assign rd_data = stat_arr[rd_ep];

endmodule

// File: rtl/usb_ep_ctrl_chk.sv
module usb_ep_ctrl_chk #(
    parameter int NUM_EP = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                cmd_valid,
    input logic [7:0]          cmd_code,
    input logic                rd_en,
    input logic [7:0]          rd_data,
    input logic                ev_setup,
    input logic                ev_setup_done,
    input logic                ev_in_ack,
    input logic                ev_out_rx,
    input logic [NUM_EP*8-1:0] stat_flat
);

    logic quiet, known_code;
    assign quiet      = !(ev_setup || ev_setup_done || ev_in_ack || ev_out_rx);
    assign known_code = (cmd_code[7:4] == 4'h4) || (cmd_code[7:4] == 4'h8) ||
                        ((cmd_code[7:4] == 4'h6) && (cmd_code[3:0] != 4'h0));

    // R13: reserved bit
    a_r13_spare_zero: assert property (@(posedge clk) disable iff (rst)
        rd_data[0] == 1'b0);

    // R2: halt command lands on the addressed endpoint
    a_r2_halt_sets: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_code[7:4] == 4'h4 |=> stat_flat[8*int'($past(cmd_code[3:0])) + 7]);

    // R3: resume leaves a clean endpoint (overwrite bit excluded)
    a_r3_resume_clean: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_code[7:4] == 4'h8 && quiet
        |=> (stat_flat[8*int'($past(cmd_code[3:0])) +: 8] & 8'hF7) == 8'h00);

    // R4: SETUP releases both control endpoints
    a_r4_setup_unhalts: assert property (@(posedge clk) disable iff (rst)
        ev_setup && !cmd_valid |=> !stat_flat[7] && !stat_flat[15]);

    // R9: SETUP over pending setup data raises the overwrite flag
    a_r9_overwrite: assert property (@(posedge clk) disable iff (rst)
        ev_setup && stat_flat[2] |=> stat_flat[3]);

    // R11: undefined codes leave every status bit alone
    a_r11_ignored: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !known_code && quiet && !rd_en |=> $stable(stat_flat));

endmodule

bind usb_ep_ctrl usb_ep_ctrl_chk #(.NUM_EP(NUM_EP)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cmd_valid     (cmd_valid),
    .cmd_code      (cmd_code),
    .rd_en         (rd_en),
    .rd_data       (rd_data),
    .ev_setup      (ev_setup),
    .ev_setup_done (ev_setup_done),
    .ev_in_ack     (ev_in_ack),
    .ev_out_rx     (ev_out_rx),
    .stat_flat     (stat_flat)
);

// File: tb/tb_usb_ep_ctrl.sv
`timescale 1ns/1ps
module tb_usb_ep_ctrl;

    logic       clk = 1'b0;
    logic       rst;
    logic       cmd_valid, rd_en, ev_setup, ev_setup_done, ev_in_ack, ev_out_rx;
    logic [7:0] cmd_code, rd_data;
    logic [3:0] rd_ep, ev_ep;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    usb_ep_ctrl dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .rd_en(rd_en), .rd_ep(rd_ep), .rd_data(rd_data),
        .ev_setup(ev_setup), .ev_setup_done(ev_setup_done),
        .ev_in_ack(ev_in_ack), .ev_out_rx(ev_out_rx), .ev_ep(ev_ep)
    );

    // Reference model
    bit m_halt[16], m_fb[16], m_fa[16], m_pid[16], m_ovw[16], m_set[16], m_cpu[16], m_usb[16];
    bit m_wip;

    typedef struct {
        logic [7:0] exp;
        int         ep;
        string      tag;
    } item_t;
    item_t sb[$];

    function automatic bit dbl(int e);
        return e >= 2;
    endfunction

    function automatic logic [7:0] m_byte(int e);
        return {m_halt[e], m_fb[e], m_fa[e], m_pid[e], m_ovw[e], m_set[e], m_cpu[e], 1'b0};
    endfunction

    task automatic m_restart(int e);
        m_halt[e] = 0; m_fb[e] = 0; m_fa[e] = 0; m_pid[e] = 0;
        m_set[e] = 0; m_cpu[e] = 0; m_usb[e] = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic cmd(input logic [7:0] c);
        int e;
        cmd_valid = 1; cmd_code = c;
        tick();
        cmd_valid = 0; cmd_code = 8'h00;
        e = int'(c[3:0]);
        if (c[7:4] == 4'h4) begin
            m_halt[e] = 1;
            if (e == 0) m_set[0] = 0;
        end else if (c[7:4] == 4'h8) begin
            m_restart(e);
        end else if (c[7:4] == 4'h6 && e != 0) begin
            if (m_cpu[e]) m_fb[e] = 1; else m_fa[e] = 1;
            if (dbl(e)) m_cpu[e] = ~m_cpu[e];
        end
    endtask

    task automatic in_ack(int e);
        ev_in_ack = 1; ev_ep = 4'(e);
        tick();
        ev_in_ack = 0;
        if (!m_halt[e] && (m_usb[e] ? m_fb[e] : m_fa[e])) begin
            if (m_usb[e]) m_fb[e] = 0; else m_fa[e] = 0;
            m_pid[e] = ~m_pid[e];
            if (dbl(e)) m_usb[e] = ~m_usb[e];
        end
    endtask

    task automatic out_rx(int e);
        ev_out_rx = 1; ev_ep = 4'(e);
        tick();
        ev_out_rx = 0;
        if (!m_halt[e] && !(m_usb[e] ? m_fb[e] : m_fa[e])) begin
            if (m_usb[e]) m_fb[e] = 1; else m_fa[e] = 1;
            m_pid[e] = ~m_pid[e];
            if (dbl(e)) m_usb[e] = ~m_usb[e];
        end
    endtask

    task automatic setup_tok();
        bit n;
        ev_setup = 1;
        tick();
        ev_setup = 0;
        n = m_ovw[0] | m_set[0];
        m_restart(0); m_restart(1);
        m_ovw[0] = n; m_wip = 1;
    endtask

    task automatic setup_done();
        ev_setup_done = 1;
        tick();
        ev_setup_done = 0;
        m_set[0] = 1; m_fa[0] = 1; m_wip = 0;
    endtask

    // Driver: queue the expected byte, then strobe the read
    task automatic rd(int e, string tag);
        item_t it;
        it.exp = m_byte(e); it.ep = e; it.tag = tag;
        sb.push_back(it);
        rd_en = 1; rd_ep = 4'(e);
        tick();
        rd_en = 0;
        if (e == 0 && !m_wip) m_ovw[0] = 0;
    endtask

    // Read of endpoint 0 together with a SETUP token (R10 same-cycle case)
    task automatic rd_with_setup(string tag);
        item_t it;
        bit clr, n;
        clr = !m_wip;
        it.exp = m_byte(0); it.ep = 0; it.tag = tag;
        sb.push_back(it);
        rd_en = 1; rd_ep = 4'd0; ev_setup = 1;
        tick();
        rd_en = 0; ev_setup = 0;
        n = (m_ovw[0] & ~clr) | m_set[0];
        m_restart(0); m_restart(1);
        m_ovw[0] = n; m_wip = 1;
    endtask

    task automatic rd_all(string tag);
        for (int e = 0; e < 16; e++) rd(e, tag);
    endtask

    // Monitor: compare at the falling edge
    always @(negedge clk) begin
        if (!rst && rd_en) begin
            item_t it;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL %s: read with empty scoreboard, got %02h expected none", "R10", rd_data);
            end else begin
                it = sb.pop_front();
                checks++;
                if (rd_data !== it.exp) begin
                    fails++;
                    $display("FAIL %s: ep %0d status got %02h expected %02h", it.tag, it.ep, rd_data, it.exp);
                end
            end
        end
    end

    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1; cmd_valid = 0; cmd_code = 0; rd_en = 0; rd_ep = 0;
        ev_setup = 0; ev_setup_done = 0; ev_in_ack = 0; ev_out_rx = 0; ev_ep = 0;
        for (int e = 0; e < 16; e++) begin
            m_restart(e); m_ovw[e] = 0;
        end
        m_wip = 0;
        repeat (3) tick();
        rst = 0;
        tick();

        rd_all("R1_R13");

        // R2 halt / resume
        cmd(8'h45); rd(5, "R2");
        cmd(8'h4F); rd(15, "R2");
        cmd(8'h85); rd(5, "R2");

        // R5 arm: single-buffered control IN, then double-buffered ep 3
        cmd(8'h61); rd(1, "R5");
        cmd(8'h63); rd(3, "R5");
        cmd(8'h63); rd(3, "R5");

        // R6 IN acknowledges
        in_ack(3); rd(3, "R6");
        in_ack(3); rd(3, "R6");
        in_ack(3); rd(3, "R6");
        in_ack(1); rd(1, "R6");

        // R7 OUT receptions, third one refused on full buffers
        out_rx(4); rd(4, "R7");
        out_rx(4); rd(4, "R7");
        out_rx(4); rd(4, "R7");

        // halted endpoint ignores traffic, then resume restarts it (R3)
        cmd(8'h44); in_ack(4); rd(4, "R6");
        cmd(8'h84); rd(4, "R3");
        cmd(8'h63); out_rx(3); cmd(8'h43); rd(3, "R3");
        cmd(8'h83); rd(3, "R3");

        // R4 SETUP releases halted control pair
        out_rx(0); cmd(8'h40); cmd(8'h41); rd(0, "R4"); rd(1, "R4");
        setup_tok(); rd(0, "R4"); rd(1, "R4");

        // R8 / R9 / R10 setup sequence
        setup_done(); rd(0, "R8");
        setup_tok();  rd(0, "R9");
        rd(0, "R10");
        setup_done(); rd(0, "R10");
        rd(0, "R10");
        rd(0, "R10");

        // R12 halt drops setup-present
        setup_tok(); setup_done();
        cmd(8'h40); rd(0, "R12");
        cmd(8'h80); rd(0, "R3");

        // R10 same-cycle overwrite beats clear-on-read
        setup_tok(); setup_done();
        setup_tok(); setup_done();
        rd_with_setup("R10");
        rd(0, "R10");
        setup_done(); rd(0, "R10"); rd(0, "R10");

        // R11 undefined codes
        cmd(8'h62); out_rx(6); cmd(8'h47);
        cmd(8'h00); cmd(8'h3F); cmd(8'h50); cmd(8'h60);
        cmd(8'h90); cmd(8'hFF); cmd(8'h7A); cmd(8'hC1);
        rd_all("R11");

        repeat (2) tick();
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R10: %0d reads left unchecked, expected 0", sb.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule